// File: doc/BRIEF.md
# Stream-to-Memory Receive DMA Channel

This block is a single receive DMA channel that drains a 32-bit data stream into memory. It takes a stream of beats (`s_tdata`, `s_tvalid`, `s_tready`, `s_tlast`) and writes each beat it accepts as one word on a simple memory write port (`mem_addr`, `mem_wdata`, `mem_we`, `mem_rdy`). Software controls it through a small register port. Software sets the run bit once. For each packet it then writes a destination address and a byte length, and the length write is what arms the channel. Software polls the idle bit to see when the packet has finished.

A state machine sequences the channel through five states:

- **HALTED**: the state after reset.
- **IDLE**: ready to be armed.
- **BUSY**: beats are being written to memory.
- **DRAIN**: the last word is still waiting on the memory port.
- **LOCKED**: entered when a packet overflows its buffer.

The transitions are:

- reset → HALTED
- HALTED → IDLE when run is set
- IDLE → HALTED when run is cleared
- IDLE → BUSY on a non-zero length write
- BUSY → DRAIN when a beat with `s_tlast` is accepted
- BUSY → LOCKED when a beat arrives with fewer than 4 bytes of buffer left
- DRAIN → IDLE once the pending memory write is taken
- any state → HALTED on a soft reset

A packet that ends early is allowed, and the byte count of the packet is kept readable. A packet that overflows its buffer freezes the channel until software issues a soft reset.

The stream ready is high from the end of reset, so beats that arrive while the channel is not armed are taken and discarded. Any upstream source must therefore be started only after the length has been written.

The register map uses 3-bit word offsets:

| Offset | Register | Contents |
|--------|----------|----------|
| 0 | CTRL | bit0 run, bit1 soft reset (self-clearing, reads 0) |
| 1 | STAT | bit0 halted, bit1 idle, bit2 error (read-only) |
| 2 | DEST | destination byte address |
| 3 | LEN | transfer length in bytes, 26 bits |
| 4 | DONE | bytes written by the current or last packet |

Top module: `s2m_dma_rx`

## Requirements
- R1: After reset, STAT reads 0x1 (halted=1, idle=0, error=0), CTRL reads 0, DONE reads 0 and `s_tready` is 1.
- R2: Writing CTRL bit0=1 moves HALTED to IDLE, and STAT then reads 0x2. The run bit stays set across any number of transfers without being rewritten.
- R3: A non-zero LEN write while idle starts a transfer and clears idle. A LEN write of zero, or any LEN write while halted, busy, draining or locked, starts nothing and leaves STAT and the current transfer unchanged.
- R4: The k-th accepted beat of a transfer (k from 0) is written with its data to address DEST+4k, in order, and DEST is captured when the transfer starts.
- R5: A beat with `s_tlast` ends the transfer. Idle returns to 1 only after that word has been taken by memory, and DONE then reads 4 times the number of beats.
- R6: A packet of N beats with `s_tlast` on beat N and a length of exactly 4N completes normally, with no error.
- R7: A beat accepted while fewer than 4 programmed bytes remain is not written to memory. The channel enters LOCKED, where STAT reads 0x4 (error=1, idle=0, halted=0) and `s_tready` is 0, and it stays there.
- R8: Writing CTRL bit1=1 from any state returns the channel to HALTED with run=0, error=0 and DONE=0.
- R9: While halted or idle, `s_tready` is 1 and accepted beats cause no memory write.
- R10: While `mem_we` is high and `mem_rdy` is low, the address and data hold stable. A second beat is not accepted until the held word is taken, and no word is lost under back-pressure.
- R11: LEN keeps only its low 26 bits; a write of 0xFFFFFFFF reads back as 0x03FFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| s_tdata | input | 32 | Stream data |
| s_tvalid | input | 1 | Stream beat valid |
| s_tlast | input | 1 | Last beat of packet |
| s_tready | output | 1 | Stream ready |
| mem_addr | output | 32 | Memory write byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_we | output | 1 | Memory write request |
| mem_rdy | input | 1 | Memory accepts the write this cycle |

## Verification
The bench first drives beats while the channel is halted and again while it is idle. A channel that treated an early ready as an armed transfer would write stray words to memory there. It then sends a packet whose `s_tlast` falls exactly on the final programmed word, and another that ends early. A design with an off-by-one in its room check would lock on the exact fit or report the wrong DONE on the early end. It rewrites LEN and DEST in the middle of a packet, where a design that failed to ignore those writes would restart or move its addresses. The bench toggles `mem_rdy` at random through random packets, and finally overflows a short buffer. A broken hold stage would drop or duplicate words under that back-pressure. A broken lock would keep accepting data or raise idle, and a broken soft reset would leave the error or the byte count set.

// File: rtl/s2m_pkg.sv
package s2m_pkg;

    typedef enum logic [2:0] {
        ST_HALTED,
        ST_IDLE,
        ST_BUSY,
        ST_DRAIN,
        ST_LOCKED
    } chan_state_t;

    localparam logic [2:0] OFS_CTRL = 3'd0;
    localparam logic [2:0] OFS_STAT = 3'd1;
    localparam logic [2:0] OFS_DEST = 3'd2;
    localparam logic [2:0] OFS_LEN  = 3'd3;
    localparam logic [2:0] OFS_DONE = 3'd4;

    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_SRST_BIT = 1;

    localparam int STAT_HALT_BIT = 0;
    localparam int STAT_IDLE_BIT = 1;
    localparam int STAT_ERR_BIT  = 2;

endpackage

// File: rtl/s2m_regs.sv
module s2m_regs
    import s2m_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              halted_i,
    input  logic              idle_i,
    input  logic              error_i,
    input  logic [LEN_W-1:0]  done_bytes_i,
    output logic              run_o,
    output logic              srst_o,
    output logic              len_go_o,
    output logic [LEN_W-1:0]  len_val_o,
    output logic [ADDR_W-1:0] dest_o
);

    logic              run_q;
    logic [ADDR_W-1:0] dest_q;
    logic [LEN_W-1:0]  len_q;

    assign srst_o    = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[CTRL_SRST_BIT];
    assign len_go_o  = reg_wr && (reg_addr == OFS_LEN);
    assign len_val_o = reg_wdata[LEN_W-1:0];
    assign run_o     = run_q;
    assign dest_o    = dest_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            dest_q <= '0;
            len_q  <= '0;
        end else begin
            if (srst_o)
                run_q <= 1'b0;
            else if (reg_wr && reg_addr == OFS_CTRL)
                run_q <= reg_wdata[CTRL_RUN_BIT];
            if (reg_wr && reg_addr == OFS_DEST)
                dest_q <= reg_wdata[ADDR_W-1:0];
            if (len_go_o)
                len_q <= len_val_o;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL: reg_rdata[CTRL_RUN_BIT] = run_q;
            OFS_STAT: begin
                reg_rdata[STAT_HALT_BIT] = halted_i;
                reg_rdata[STAT_IDLE_BIT] = idle_i;
                reg_rdata[STAT_ERR_BIT]  = error_i;
            end
            OFS_DEST: reg_rdata[ADDR_W-1:0] = dest_q;
            OFS_LEN:  reg_rdata[LEN_W-1:0]  = len_q;
            OFS_DONE: reg_rdata[LEN_W-1:0]  = done_bytes_i;
            default:  reg_rdata = '0;
        endcase
    end

    // R8
    srst_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst_o |=> !run_o);

    // R2
    run_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && !reg_wr) |=> run_o);

endmodule

// File: rtl/s2m_wbuf.sv
module s2m_wbuf #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              push_i,
    input  logic [ADDR_W-1:0] push_addr_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              mem_rdy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              space_o,
    output logic              valid_o
);

    logic              held_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    assign space_o   = !held_q || mem_rdy;
    assign valid_o   = held_q;
    assign mem_we    = held_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else if (flush_i) begin
            held_q <= 1'b0;
        end else if (push_i) begin
            held_q <= 1'b1;
            addr_q <= push_addr_i;
            data_q <= push_data_i;
        end else if (mem_rdy) begin
            held_q <= 1'b0;
        end
    end

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_rdy && !flush_i) |=> (mem_we && $stable(mem_addr) && $stable(mem_wdata)));

    // R10
    no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q && !mem_rdy) |-> !push_i);

endmodule

// File: rtl/s2m_seq.sv
module s2m_seq
    import s2m_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              srst_i,
    input  logic              len_go_i,
    input  logic [LEN_W-1:0]  len_val_i,
    input  logic [ADDR_W-1:0] dest_i,
    input  logic              s_tvalid,
    input  logic              s_tlast,
    output logic              s_tready,
    input  logic              wb_space_i,
    input  logic              wb_valid_i,
    input  logic              mem_rdy_i,
    output logic              push_o,
    output logic [ADDR_W-1:0] push_addr_o,
    output logic              halted_o,
    output logic              idle_o,
    output logic              error_o,
    output logic [LEN_W-1:0]  done_bytes_o
);

    localparam int BEAT_B = DATA_W / 8;

    chan_state_t       state_q, state_d;
    logic [ADDR_W-1:0] cur_addr_q;
    logic [LEN_W-1:0]  remain_q;
    logic [LEN_W-1:0]  done_q;
    logic [LEN_W-1:0]  prog_len_q;
    logic              fire;
    logic              room;
    logic              start;

    assign fire  = s_tvalid && s_tready;
    assign room  = remain_q >= LEN_W'(BEAT_B);
    assign start = (state_q == ST_IDLE) && run_i && len_go_i && (len_val_i != '0) && !srst_i;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (srst_i) begin
            state_d = ST_HALTED;
        end else begin
            unique case (state_q)
                ST_HALTED: if (run_i) state_d = ST_IDLE;
                ST_IDLE: begin
                    if (!run_i)
                        state_d = ST_HALTED;
                    else if (start)
                        state_d = ST_BUSY;
                end
                ST_BUSY: begin
                    if (fire && !room)
                        state_d = ST_LOCKED;
                    else if (fire && s_tlast)
                        state_d = ST_DRAIN;
                end
                ST_DRAIN:  if (!wb_valid_i || mem_rdy_i) state_d = ST_IDLE;
                ST_LOCKED: state_d = ST_LOCKED;
                default:   state_d = ST_HALTED;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_HALTED;
        else
            state_q <= state_d;
    end

    // outputs
    always_comb begin
        s_tready = 1'b1;
        halted_o = 1'b0;
        idle_o   = 1'b0;
        error_o  = 1'b0;
        push_o   = 1'b0;
        unique case (state_q)
            ST_HALTED: halted_o = 1'b1;
            ST_IDLE:   idle_o   = 1'b1;
            ST_BUSY: begin
                s_tready = wb_space_i;
                push_o   = fire && room;
            end
            ST_DRAIN:  s_tready = 1'b1;
            ST_LOCKED: begin
                s_tready = 1'b0;
                error_o  = 1'b1;
            end
            default:   halted_o = 1'b1;
        endcase
    end

    assign push_addr_o  = cur_addr_q;
    assign done_bytes_o = done_q;

    // transfer datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr_q <= '0;
            remain_q   <= '0;
            done_q     <= '0;
            prog_len_q <= '0;
        end else if (srst_i) begin
            remain_q   <= '0;
            done_q     <= '0;
            prog_len_q <= '0;
        end else if (start) begin
            cur_addr_q <= dest_i;
            remain_q   <= len_val_i;
            done_q     <= '0;
            prog_len_q <= len_val_i;
        end else if (push_o) begin
            cur_addr_q <= cur_addr_q + ADDR_W'(BEAT_B);
            remain_q   <= remain_q - LEN_W'(BEAT_B);
            done_q     <= done_q + LEN_W'(BEAT_B);
        end
    end

    // R7
    no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q <= prog_len_q);

    // R7
    lock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error_o) |-> $past(fire));

    // R5
    idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> !wb_valid_i);

    // R9
    no_write_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o || idle_o) |-> (!push_o && s_tready));

    // R1
    one_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({halted_o, idle_o, error_o}));

endmodule

// File: rtl/s2m_dma_rx.sv
module s2m_dma_rx #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tvalid,
    input  logic              s_tlast,
    output logic              s_tready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic              mem_rdy
);

    logic              run, srst, len_go;
    logic [LEN_W-1:0]  len_val, done_bytes;
    logic [ADDR_W-1:0] dest, push_addr;
    logic              halted, idle, error;
    logic              push, wb_space, wb_valid;

    s2m_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .halted_i     (halted),
        .idle_i       (idle),
        .error_i      (error),
        .done_bytes_i (done_bytes),
        .run_o        (run),
        .srst_o       (srst),
        .len_go_o     (len_go),
        .len_val_o    (len_val),
        .dest_o       (dest)
    );

    s2m_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run),
        .srst_i       (srst),
        .len_go_i     (len_go),
        .len_val_i    (len_val),
        .dest_i       (dest),
        .s_tvalid     (s_tvalid),
        .s_tlast      (s_tlast),
        .s_tready     (s_tready),
        .wb_space_i   (wb_space),
        .wb_valid_i   (wb_valid),
        .mem_rdy_i    (mem_rdy),
        .push_o       (push),
        .push_addr_o  (push_addr),
        .halted_o     (halted),
        .idle_o       (idle),
        .error_o      (error),
        .done_bytes_o (done_bytes)
    );

    s2m_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wbuf (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (srst),
        .push_i      (push),
        .push_addr_i (push_addr),
        .push_data_i (s_tdata),
        .mem_rdy     (mem_rdy),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .space_o     (wb_space),
        .valid_o     (wb_valid)
    );

endmodule

// File: tb/s2m_dma_rx_tb.sv
`timescale 1ns/100ps
module s2m_dma_rx_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] s_tdata = '0;
    logic        s_tvalid = 1'b0;
    logic        s_tlast = 1'b0;
    logic        s_tready;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_we;
    logic        mem_rdy = 1'b1;

    always #2.5 clk = ~clk;

    s2m_dma_rx u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .s_tdata(s_tdata),
        .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdy(mem_rdy)
    );

    logic [31:0] mem [0:1023];
    int          wr_cnt = 0;
    bit          rdy_rand = 1'b0;
    int          n_chk = 0;
    int          n_err = 0;
    bit          ended = 1'b0;

    always @(posedge clk) begin
        if (mem_we && mem_rdy) begin
            mem[mem_addr[11:2]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    always @(negedge clk) mem_rdy <= rdy_rand ? (($urandom % 4) != 0) : 1'b1;

    function automatic logic [31:0] pat(logic [31:0] base, int k);
        return (base ^ (32'(k) * 32'h0101_0101)) + 32'(k);
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic send(logic [31:0] data, logic last, output bit acc);
        @(negedge clk);
        s_tvalid = 1'b1; s_tdata = data; s_tlast = last;
        acc = 1'b0;
        for (int g = 0; g < 300; g++) begin
            #1;
            if (s_tready) begin
                acc = 1'b1;
                @(posedge clk);
                break;
            end
            @(negedge clk);
        end
        #1 s_tvalid = 1'b0; s_tlast = 1'b0;
    endtask

    task automatic wait_idle(output bit ok);
        logic [31:0] st;
        ok = 1'b0;
        for (int g = 0; g < 500; g++) begin
            rd_reg(3'd1, st);
            if (st[1]) begin ok = 1'b1; break; end
        end
    endtask

    // Sends one packet of n beats and checks memory and DONE against the requirements.
    task automatic packet(string req, logic [31:0] dest, int n, int len_b, logic [31:0] base);
        bit acc, ok;
        int w0;
        logic [31:0] v;
        w0 = wr_cnt;
        wr_reg(3'd2, dest);
        wr_reg(3'd3, 32'(len_b));
        for (int k = 0; k < n; k++) send(pat(base, k), k == n - 1, acc);
        wait_idle(ok);
        chk(req, "idle after packet (R5)", 32'(ok), 32'd1);
        rd_reg(3'd4, v);
        chk(req, "DONE bytes (R5)", v, 32'(4 * n));
        chk(req, "write count (R4)", 32'(wr_cnt - w0), 32'(n));
        for (int k = 0; k < n; k++)
            chk(req, $sformatf("word %0d (R4)", k), mem[dest[11:2] + 10'(k)], pat(base, k));
    endtask

    initial begin
        logic [31:0] v;
        bit acc, ok;
        int w0, n, extra;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd_reg(3'd1, v); chk("R1", "STAT after reset", v, 32'h1);
        rd_reg(3'd0, v); chk("R1", "CTRL after reset", v, 32'h0);
        rd_reg(3'd4, v); chk("R1", "DONE after reset", v, 32'h0);
        chk("R1", "tready after reset", 32'(s_tready), 32'd1);

        // R9 beats while halted are dropped
        w0 = wr_cnt;
        for (int k = 0; k < 3; k++) send(32'hDEAD_0000 + 32'(k), k == 2, acc);
        chk("R9", "accepted while halted", 32'(acc), 32'd1);
        repeat (3) @(posedge clk);
        chk("R9", "writes while halted", 32'(wr_cnt - w0), 32'd0);

        // R3 / R11 length write while halted
        wr_reg(3'd3, 32'hFFFF_FFFF);
        rd_reg(3'd1, v); chk("R3", "STAT after halted LEN write", v, 32'h1);
        rd_reg(3'd3, v); chk("R11", "LEN readback", v, 32'h03FF_FFFF);

        // R2 run
        wr_reg(3'd0, 32'h1);
        rd_reg(3'd1, v); chk("R2", "STAT after run", v, 32'h2);

        // R9 beats while idle dropped
        w0 = wr_cnt;
        send(32'h1234_5678, 1'b1, acc);
        repeat (3) @(posedge clk);
        chk("R9", "writes while idle", 32'(wr_cnt - w0), 32'd0);

        // R3 zero length ignored
        wr_reg(3'd3, 32'h0);
        rd_reg(3'd1, v); chk("R3", "STAT after zero LEN", v, 32'h2);

        // R6 exact fit 32 beats, 128 bytes
        packet("R6", 32'h0000_0100, 32, 128, 32'h0A0B_0C00);
        rd_reg(3'd1, v); chk("R6", "STAT after exact fit", v, 32'h2);

        // R5 early end: 5 beats in a 64-byte buffer
        packet("R5", 32'h0000_0300, 5, 64, 32'h5500_0000);

        // R3 writes during a transfer are ignored
        w0 = wr_cnt;
        wr_reg(3'd2, 32'h0000_0500);
        wr_reg(3'd3, 32'd40);
        send(pat(32'h7700_0000, 0), 1'b0, acc);
        send(pat(32'h7700_0000, 1), 1'b0, acc);
        wr_reg(3'd2, 32'h0000_0900);
        wr_reg(3'd3, 32'd8);
        rd_reg(3'd1, v); chk("R3", "STAT busy after LEN rewrite", v, 32'h0);
        for (int k = 2; k < 10; k++) send(pat(32'h7700_0000, k), k == 9, acc);
        wait_idle(ok);
        rd_reg(3'd4, v); chk("R3", "DONE after mid-transfer rewrite", v, 32'd40);
        chk("R3", "write count", 32'(wr_cnt - w0), 32'd10);
        chk("R3", "last word at old dest", mem[10'h140 + 10'd9], pat(32'h7700_0000, 9));

        // R10 random packets with memory back-pressure
        rdy_rand = 1'b1;
        for (int p = 0; p < 6; p++) begin
            n = 1 + int'($urandom % 24);
            extra = int'($urandom % 4);
            packet("R10", 32'h0000_0600 + 32'(p * 8), n, 4 * (n + extra), $urandom);
        end
        rdy_rand = 1'b0;

        // R7 overflow lock
        w0 = wr_cnt;
        wr_reg(3'd2, 32'h0000_0800);
        wr_reg(3'd3, 32'd16);
        for (int k = 0; k < 5; k++) send(32'hC0DE_0000 + 32'(k), 1'b0, acc);
        repeat (3) @(posedge clk);
        rd_reg(3'd1, v); chk("R7", "STAT locked", v, 32'h4);
        chk("R7", "tready locked", 32'(s_tready), 32'd0);
        chk("R7", "writes before lock", 32'(wr_cnt - w0), 32'd4);
        chk("R7", "overflow word not written", mem[10'h204], 32'h0);
        rd_reg(3'd4, v); chk("R7", "DONE locked", v, 32'd16);
        wr_reg(3'd3, 32'd8);
        repeat (4) @(posedge clk);
        rd_reg(3'd1, v); chk("R7", "still locked after LEN write (R3)", v, 32'h4);

        // R8 soft reset
        wr_reg(3'd0, 32'h2);
        rd_reg(3'd1, v); chk("R8", "STAT after soft reset", v, 32'h1);
        rd_reg(3'd0, v); chk("R8", "CTRL after soft reset", v, 32'h0);
        rd_reg(3'd4, v); chk("R8", "DONE after soft reset", v, 32'h0);
        chk("R8", "tready after soft reset", 32'(s_tready), 32'd1);
        wr_reg(3'd0, 32'h1);
        packet("R8", 32'h0000_0A00, 4, 16, 32'hBEEF_0000);

        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!ended) begin
            ended = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule